// File: doc/BRIEF.md
# Multi-channel control register file

This block holds the configuration of three data channels behind a small command bus. Each channel owns one read-write control word (enable, two-bit priority, three-bit packet length code) and one read-only status word that mirrors the channel's free-space count. Software-side logic drives a two-bit command, an eight-bit address and write data. The block decodes the address into a bank and a channel, stores or ignores the write, and returns registered read data.

The control fields are driven out continuously, so the channel data path, the arbiter and the packer downstream see new settings one cycle after a write lands. The upper address nibble picks the bank: 0 selects control and 1 selects status. Address bits [3:2] pick the channel. Any other decode returns zero and changes nothing.

Top module: `chcfg_regfile`

## Requirements
- R1: Command encoding is 0 = IDLE, 1 = READ, 2 = WRITE, 3 = reserved. IDLE and reserved change no register, and `cmd_rdata` is 0 in the cycle after any command that is not READ.
- R2: While reset is low, and in the first cycle after it is released, every channel shows enable 1, priority 3 and length code 0. A status read sampled on the first edge after reset returns 0x20.
- R3: A WRITE to address bank 0 (bits [7:4] = 0) with channel index `c` = bits [3:2] < 3 stores enable from data bit 0, priority from bits [2:1] and length code from bits [5:3]. The new values appear on the outputs in the cycle after the edge that samples the WRITE. `ch_len_o` carries the low two bits of the length code.
- R4: Write data bits above bit 5 are discarded. A READ of a control address returns the stored six-bit word, zero-extended.
- R5: A READ is answered on `cmd_rdata` in the cycle after the edge that samples it, and only in that cycle.
- R6: A READ of bank 1 (bits [7:4] = 1) with channel index below 3 returns that channel's free-space count, zero-extended. The count is the one captured on the clock edge before the one that samples the READ.
- R7: A WRITE to a status address changes no control output.
- R8: Channel index 3 in either bank (0x0C-0x0F, 0x1C-0x1F) and every address of 0x20 and above are illegal. WRITEs there change nothing, and READs there return 0.
- R9: Address bits [1:0] are ignored in the decode.
- R10: A WRITE to one channel leaves the control fields of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 2 | Command: 0 idle, 1 read, 2 write, 3 reserved |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | DATA_W (32) | Write data |
| cmd_rdata | output | DATA_W (32) | Registered read data |
| free_space_i | input | NCH*CNT_W (24) | Free-space count per channel, channel 0 in the low byte |
| ch_en_o | output | NCH (3) | Channel enable |
| ch_prio_o | output | NCH*2 (6) | Channel priority, 2 bits per channel |
| ch_len_o | output | NCH*2 (6) | Low two bits of each channel's length code |

## Verification
The hardest case to reach from the ports is the status reset value. The status word follows its input on every clock, so the value 0x20 can only be seen on a READ that is sampled on the very first edge after reset is released. The bench drives a free-space count different from 0x20 and raises reset together with a READ of a status address on the same falling edge, so the reset value is the only correct answer. Every one of the 256 addresses is then written with data whose upper bits are set and read back. This reaches every illegal hole, each alias of the ignored low address bits, and channel isolation, all checked against an arithmetic model.

// File: rtl/chcfg_pkg.sv
// Package: shared command encoding and control-word layout for the
// channel configuration register file. Assumes three-bit length code,
// two-bit priority and one enable bit, packed with enable at bit 0.
package chcfg_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    localparam int LEN_W  = 3;
    localparam int PRIO_W = 2;
    localparam int CTRL_W = LEN_W + PRIO_W + 1;
    localparam int LEN_OUT_W = 2;

    localparam logic [3:0] BANK_CTRL = 4'd0;
    localparam logic [3:0] BANK_STAT = 4'd1;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [PRIO_W-1:0] prio;
        logic              en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{len: '0, prio: 2'd3, en: 1'b1};

endpackage

// File: rtl/chcfg_addr_dec.sv
// Module: address decoder. Splits the address into a bank (bits [7:4])
// and a channel index (bits [3:2]) and raises one-hot hit lines per
// channel. Assumes NCH <= 4; bits [1:0] are not decoded.
module chcfg_addr_dec
    import chcfg_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic [7:0]     addr,
    output logic [NCH-1:0] ctrl_hit,
    output logic [NCH-1:0] stat_hit
);

    logic [3:0] bank;
    logic [1:0] idx;

    // Purpose: slice the address fields used by the decode.
    always_comb begin
        bank = addr[7:4];
        idx  = addr[3:2];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        // Purpose: match this channel in each bank.
        always_comb begin
            ctrl_hit[i] = (bank == BANK_CTRL) && (idx == 2'(i));
            stat_hit[i] = (bank == BANK_STAT) && (idx == 2'(i));
        end
    end

endmodule

// File: rtl/chcfg_chan.sv
// Module: per-channel storage. Holds the control word and a copy of the
// free-space count captured on every clock. Assumes the caller has
// already qualified wr_en with command and decode.
module chcfg_chan
    import chcfg_pkg::*;
#(
    parameter int              CNT_W    = 8,
    parameter logic [CNT_W-1:0] STAT_RST = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ctrl_t            wr_val,
    input  logic [CNT_W-1:0] free_in,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] stat_q
);

    // Purpose: control word, loaded only on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            ctrl_q <= wr_val;
        end
    end

    // Purpose: status word, follows the free-space input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RST;
        end else begin
            stat_q <= free_in;
        end
    end

endmodule

// File: rtl/chcfg_rd_port.sv
// Module: read-back port. Selects the addressed word among all channels
// and registers it; outputs zero whenever the sampled command is not a
// READ or the address hit nothing. Assumes at most one hit line is set.
module chcfg_rd_port
    import chcfg_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [NCH-1:0]             ctrl_hit,
    input  logic [NCH-1:0]             stat_hit,
    input  logic [NCH-1:0][CTRL_W-1:0] ctrl_all,
    input  logic [NCH-1:0][CNT_W-1:0]  stat_all,
    output logic [DATA_W-1:0]          rdata
);

    logic [DATA_W-1:0] rd_next;

    // Purpose: OR-combine the zero-extended word of the hit register.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ctrl_hit[i]) rd_next = rd_next | DATA_W'(ctrl_all[i]);
            if (stat_hit[i]) rd_next = rd_next | DATA_W'(stat_all[i]);
        end
    end

    // Purpose: register the answer; zero unless a READ was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/chcfg_regfile.sv
// Module: top of the channel configuration register file. Decodes the
// command bus, updates per-channel control words, mirrors free-space
// counts and returns registered read data. Assumes NCH <= 4 and
// DATA_W >= CNT_W >= CTRL_W.
module chcfg_regfile
    import chcfg_pkg::*;
#(
    parameter int               NCH      = 3,
    parameter int               CNT_W    = 8,
    parameter int               DATA_W   = 32,
    parameter logic [CNT_W-1:0] STAT_RST = 8'h20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cmd_op,
    input  logic [7:0]              cmd_addr,
    input  logic [DATA_W-1:0]       cmd_wdata,
    output logic [DATA_W-1:0]       cmd_rdata,
    input  logic [NCH*CNT_W-1:0]    free_space_i,
    output logic [NCH-1:0]          ch_en_o,
    output logic [NCH*PRIO_W-1:0]   ch_prio_o,
    output logic [NCH*LEN_OUT_W-1:0] ch_len_o
);

    cmd_e                       op;
    logic                       is_wr;
    logic                       is_rd;
    ctrl_t                      wr_val;
    logic [NCH-1:0]             ctrl_hit;
    logic [NCH-1:0]             stat_hit;
    logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
    logic [NCH-1:0][CNT_W-1:0]  stat_all;

    // Purpose: classify the command and mask write data to the field width.
    always_comb begin
        op     = cmd_e'(cmd_op);
        is_wr  = (op == CMD_WRITE);
        is_rd  = (op == CMD_READ);
        wr_val = ctrl_t'(cmd_wdata[CTRL_W-1:0]);
    end

    chcfg_addr_dec #(.NCH(NCH)) u_dec (
        .addr     (cmd_addr),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ctrl_t ctrl_q;
        logic  wr_en;

        // Purpose: this channel's write strobe.
        always_comb wr_en = is_wr && ctrl_hit[i];

        chcfg_chan #(.CNT_W(CNT_W), .STAT_RST(STAT_RST)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_val  (wr_val),
            .free_in (free_space_i[i*CNT_W +: CNT_W]),
            .ctrl_q  (ctrl_q),
            .stat_q  (stat_all[i])
        );

        // Purpose: fan the stored fields out to the channel outputs.
        always_comb begin
            ctrl_all[i]                          = ctrl_q;
            ch_en_o[i]                           = ctrl_q.en;
            ch_prio_o[i*PRIO_W +: PRIO_W]        = ctrl_q.prio;
            ch_len_o[i*LEN_OUT_W +: LEN_OUT_W]   = ctrl_q.len[LEN_OUT_W-1:0];
        end
    end

    chcfg_rd_port #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (is_rd),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit),
        .ctrl_all (ctrl_all),
        .stat_all (stat_all),
        .rdata    (cmd_rdata)
    );

endmodule

// File: rtl/chcfg_regfile_chk.sv
// Module: assertion checker bound to chcfg_regfile. Watches only ports.
module chcfg_regfile_chk #(
    parameter int NCH    = 3,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cmd_op,
    input logic [7:0]           cmd_addr,
    input logic [DATA_W-1:0]    cmd_wdata,
    input logic [DATA_W-1:0]    cmd_rdata,
    input logic [NCH-1:0]       ch_en_o,
    input logic [NCH*2-1:0]     ch_prio_o,
    input logic [NCH*2-1:0]     ch_len_o
);

    // R1 / R5: no READ sampled means zero read data.
    p_nonread_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_op) != 2'd1) |-> (cmd_rdata == '0));

    // R4 / R6: read data never exceeds the widest register.
    p_rdata_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata >> CNT_W) == '0);

    // R8: illegal reads answer zero.
    p_illegal_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_op) == 2'd1 &&
         ($past(cmd_addr[7:5]) != 3'd0 || $past(cmd_addr[3:2]) >= 2'(NCH)))
        |-> (cmd_rdata == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_p
        // R2: outputs carry reset defaults right after reset.
        p_reset_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (ch_en_o[i] && ch_prio_o[i*2 +: 2] == 2'd3 &&
                               ch_len_o[i*2 +: 2] == 2'd0));

        // R7 / R8 / R10: no decoded write to this channel, no change.
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !($past(cmd_op) == 2'd2 && $past(cmd_addr[7:4]) == 4'd0 &&
                               $past(cmd_addr[3:2]) == 2'(i)))
            |-> ($stable(ch_en_o[i]) && $stable(ch_prio_o[i*2 +: 2]) &&
                 $stable(ch_len_o[i*2 +: 2])));

        // R3: a decoded write lands in the following cycle.
        p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(cmd_op) == 2'd2 && $past(cmd_addr[7:4]) == 4'd0 &&
             $past(cmd_addr[3:2]) == 2'(i))
            |-> (ch_en_o[i] == $past(cmd_wdata[0]) &&
                 ch_prio_o[i*2 +: 2] == $past(cmd_wdata[2:1]) &&
                 ch_len_o[i*2 +: 2] == $past(cmd_wdata[4:3])));
    end

endmodule

bind chcfg_regfile chcfg_regfile_chk #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .ch_en_o   (ch_en_o),
    .ch_prio_o (ch_prio_o),
    .ch_len_o  (ch_len_o)
);

// File: tb/chcfg_regfile_tb.sv
// Bench: exhaustive address sweep with an arithmetic model.
module chcfg_regfile_tb;

    localparam int NCH = 3;
    localparam int CNT_W = 8;
    localparam int DATA_W = 32;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            cmd_op = 2'd0;
    logic [7:0]            cmd_addr = '0;
    logic [DATA_W-1:0]     cmd_wdata = '0;
    logic [DATA_W-1:0]     cmd_rdata;
    logic [NCH*CNT_W-1:0]  free_space_i = '0;
    logic [NCH-1:0]        ch_en_o;
    logic [NCH*2-1:0]      ch_prio_o;
    logic [NCH*2-1:0]      ch_len_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [5:0] mdl [NCH];
    logic [7:0] fr  [NCH];

    always #5 clk = ~clk;

    chcfg_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .free_space_i(free_space_i),
        .ch_en_o(ch_en_o), .ch_prio_o(ch_prio_o), .ch_len_o(ch_len_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Issue one command at a falling edge; return at the next falling edge.
    task automatic op(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d);
        cmd_op = c; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_op = 2'd0;
    endtask

    task automatic chk_outs(input string req);
        for (int i = 0; i < NCH; i++) begin
            logic [4:0] act, exp;
            act = {ch_len_o[i*2 +: 2], ch_prio_o[i*2 +: 2], ch_en_o[i]};
            exp = mdl[i][4:0];
            chk(act == exp, req, 32'(act), 32'(exp));
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[7:4] == 4'd0 && a[3:2] < 2'(NCH)) return 32'(mdl[a[3:2]]);
        if (a[7:4] == 4'd1 && a[3:2] < 2'(NCH)) return 32'(fr[a[3:2]]);
        return 32'd0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) mdl[i] = {3'd0, 2'd3, 1'b1};
        free_space_i = {NCH{8'h05}};
        repeat (3) @(negedge clk);
        chk_outs("R2 during reset");
        // First edge after release samples a status READ: reset value 0x20.
        rst_n = 1'b1;
        op(2'd1, 8'h14, 32'd0);
        chk(cmd_rdata == 32'h20, "R2 status reset", cmd_rdata, 32'h20);
        chk_outs("R2 after release");
        op(2'd0, 8'h00, 32'd0);
        chk(cmd_rdata == 0, "R5 read held one cycle", cmd_rdata, 0);

        for (int i = 0; i < NCH; i++) begin
            fr[i] = 8'(8'h41 + i * 8'h37);
            free_space_i[i*8 +: 8] = fr[i];
        end
        @(negedge clk);

        // IDLE and reserved commands with live addresses and data.
        op(2'd0, 8'h04, 32'h0000_003E);
        chk(cmd_rdata == 0, "R1 idle rdata", cmd_rdata, 0);
        chk_outs("R1 idle no change");
        op(2'd3, 8'h08, 32'h0000_0000);
        chk(cmd_rdata == 0, "R1 reserved rdata", cmd_rdata, 0);
        chk_outs("R1 reserved no change");

        // Exhaustive sweep: write then read every address.
        for (int a = 0; a < 256; a++) begin
            logic [7:0]  ad;
            logic [31:0] d;
            string tw, tr;
            ad = 8'(a);
            d  = 32'hDEAD_0000 | 32'((a * 53 + 29) & 255);
            if (ad[7:4] == 0 && ad[3:2] < 2'(NCH)) begin
                mdl[ad[3:2]] = d[5:0];
                tw = "R3 R10 write"; tr = "R4 R9 ctrl read";
            end else if (ad[7:4] == 1 && ad[3:2] < 2'(NCH)) begin
                tw = "R7 status write"; tr = "R6 status read";
            end else begin
                tw = "R8 illegal write"; tr = "R8 illegal read";
            end
            op(2'd2, ad, d);
            chk(cmd_rdata == 0, "R1 write rdata", cmd_rdata, 0);
            chk_outs(tw);
            op(2'd1, ad, 32'hFFFF_FFFF);
            chk(cmd_rdata == exp_rd(ad), tr, cmd_rdata, exp_rd(ad));
        end

        // Status follows a changed count; read one edge after capture.
        free_space_i[8 +: 8] = 8'hFF; fr[1] = 8'hFF;
        @(negedge clk);
        op(2'd1, 8'h17, 32'd0);
        chk(cmd_rdata == 32'hFF, "R6 new count", cmd_rdata, 32'hFF);
        op(2'd0, 8'h17, 32'd0);
        chk(cmd_rdata == 0, "R5 answer one cycle only", cmd_rdata, 0);

        finish_run();
    end

endmodule